// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous, pipelined static RAM. Each word holds two byte lanes, and each lane carries eight data bits and one parity bit. Every control and address input is captured on the rising clock edge. An active-low clock enable qualifies each capture. When that enable is high, the whole pipeline freezes and the previous cycle is extended. The device stays selected during such a stall.

A read address taken on one enabled edge returns its data on the bus after the next enabled edge. Write data and its byte-lane selects are taken on the second enabled edge after the write address. Reads and writes can therefore alternate on every cycle with no idle cycle on the shared bus. An on-chip two-bit burst counter steps the low address bits on advance cycles. A static strap picks either linear or interleaved stepping. Three chip selects of mixed polarity gate each load cycle. An asynchronous active-low output enable gates the bus drive.

The storage depth is `2**ADDR_W` words. A full-size instance uses `ADDR_W = 18`. The default is kept small so that the model elaborates quickly. The data bus is split into an input half, an output half and a drive-enable flag. A board-level wrapper can merge these three into a tri-state pin.

Top module: `nobl_sram`

## Requirements
- R1: A load cycle (adv_ld low, cen_n low) selects the device only when ce1_n is 0, ce2 is 1 and ce3_n is 0. On any other combination, that cycle is a deselect: nothing is written, and no data is driven for it.
- R2: A read loaded on enabled edge k drives its word on dq_o with dq_oe high from enabled edge k+1 until the next enabled edge, provided oe_n is low.
- R3: For a write loaded on enabled edge k, the word on dq_i and the lane selects on bws_n are sampled on enabled edge k+2. The bus is not driven during that data phase.
- R4: Lane 0 is written only when bws_n[0] is 0; it covers dq bits 7:0 and parity bit 16. Lane 1 is written only when bws_n[1] is 0; it covers dq bits 15:8 and parity bit 17. Unselected lanes keep their old contents.
- R5: A read loaded on the edge after a write to the same address returns the newly written lanes, merged with the untouched old lanes.
- R6: While cen_n is high, no input is acted on and no stored word changes. The bus output and drive state hold their values.
- R7: An advance cycle (adv_ld high, cen_n low) repeats the type of the last loaded access at the next burst address, and ignores we_n, the address and the chip selects. An advance after a deselect, or straight after reset, performs no access.
- R8: With burst_mode at 0 (linear), the low two address bits of beat n are (loaded low bits + n) mod 4. The upper bits do not change.
- R9: With burst_mode at 1 (interleaved), the low two address bits of beat n are (loaded low bits) XOR (n mod 4).
- R10: dq_oe stays low, whatever oe_n says, in three cases: during a write data phase, while a deselect is in the output stage, and on the first cycle after leaving the deselected state.
- R11: oe_n high forces dq_oe low at once, without waiting for a clock edge.
- R12: After a synchronous reset (rst_n low on a rising edge), the pipeline is empty, dq_oe is low and no burst is live.
- R13: Reads and writes to different addresses may alternate on consecutive cycles, with every read returning correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, taken on load cycles |
| adv_ld | input | 1 | 0 = load new access, 1 = advance burst |
| we_n | input | 1 | Active-low write on load cycles |
| bws_n | input | 2 | Active-low lane write selects, taken in the data phase |
| ce1_n | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| ce3_n | input | 1 | Active-low chip select |
| cen_n | input | 1 | Active-low clock enable |
| oe_n | input | 1 | Asynchronous active-low output enable |
| burst_mode | input | 1 | Static strap: 1 = interleaved, 0 = linear |
| dq_i | input | 18 | Write data {parity[1:0], data[15:0]} |
| dq_o | output | 18 | Read data, same layout as dq_i |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
The embedded properties run on every cycle. They check that a deselect leaves no access behind, and that an advance with no live burst issues nothing. They also check that a burst step keeps the upper address bits and always changes the low two bits. Further properties cover a stall freezing the read register, reads moving into the output stage, and the bus staying off during write data phases and after deselects. Correct stored contents, lane masking, the same-address bypass, the exact beat order in each mode and the asynchronous output-enable gating are shown only by the bench scenarios. The bench compares each of these against its reference array.

// File: rtl/nobl_sram_pkg.sv
// Shared word geometry for the pipelined SRAM model.
// Assumes two byte lanes, each carrying its own parity bit above the data field.
package nobl_sram_pkg;
    localparam int LANES     = 2;
    localparam int LANE_BITS = 8;
    localparam int DATA_W    = LANES * LANE_BITS;
    localparam int WORD_W    = DATA_W + LANES;
endpackage

// File: rtl/nobl_burst_ctrl.sv
// Load/advance front end: decodes the chip selects, runs the two-bit burst
// counter and registers one access per enabled edge (pipeline stage 1).
// Assumes ADDR_W >= 2 and a burst_mode strap that does not change while a burst is live.
module nobl_burst_ctrl #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              burst_mode,
    output logic              op_valid,
    output logic              op_wr,
    output logic [ADDR_W-1:0] op_addr
);
    localparam int CNT_W = 2;

    logic              sel;
    logic              live;
    logic              last_wr;
    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  nxt_cnt;
    logic [CNT_W-1:0]  step_lo;

    // Select decode and next burst address bits for the chosen order.
    always_comb begin
        sel     = ~ce1_n & ce2 & ~ce3_n;
        nxt_cnt = cnt + 1'b1;
        step_lo = burst_mode ? (base[CNT_W-1:0] ^ nxt_cnt)
                             : (base[CNT_W-1:0] + nxt_cnt);
    end

    // Burst state and stage-1 access register, moved only on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live     <= 1'b0;
            last_wr  <= 1'b0;
            base     <= '0;
            cnt      <= '0;
            op_valid <= 1'b0;
            op_wr    <= 1'b0;
            op_addr  <= '0;
        end else if (en) begin
            if (!adv_ld) begin
                live     <= sel;
                base     <= addr;
                cnt      <= '0;
                last_wr  <= ~we_n;
                op_valid <= sel;
                op_wr    <= sel & ~we_n;
                op_addr  <= addr;
            end else if (live) begin
                cnt      <= nxt_cnt;
                op_valid <= 1'b1;
                op_wr    <= last_wr;
                op_addr  <= {base[ADDR_W-1:CNT_W], step_lo};
            end else begin
                op_valid <= 1'b0;
                op_wr    <= 1'b0;
            end
        end
    end

    // A deselecting load leaves stage 1 empty.
    p_desel_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adv_ld && !sel) |=> !op_valid);

    // An advance without a live burst issues nothing.
    p_no_adv_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv_ld && !live) |=> !op_valid);

    // A burst step stays within its four-word block.
    p_burst_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv_ld && live) |=> (op_valid &&
            op_addr[ADDR_W-1:CNT_W] == $past(op_addr[ADDR_W-1:CNT_W])));

    // Every step moves the low bits in either order (R8, R9).
    p_burst_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv_ld && live) |=> op_addr[CNT_W-1:0] != $past(op_addr[CNT_W-1:0]));
endmodule

// File: rtl/nobl_pipe.sv
// Output stage (pipeline stage 2): holds the access whose data phase is on the
// bus now, and forms the bus drive enable from it and the asynchronous oe_n.
// Assumes stage 1 is presented by the burst controller.
module nobl_pipe #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              oe_n,
    output logic              s2_valid,
    output logic              s2_wr,
    output logic [ADDR_W-1:0] s2_addr,
    output logic              dq_oe
);
    // Advance stage 2 on enabled edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_wr    <= 1'b0;
            s2_addr  <= '0;
        end else if (en) begin
            s2_valid <= in_valid;
            s2_wr    <= in_wr;
            s2_addr  <= in_addr;
        end
    end

    // Drive only a read in its data phase, gated at once by oe_n.
    assign dq_oe = ~oe_n & s2_valid & ~s2_wr;

    // A read accepted by stage 1 reaches the output stage on the next enabled edge.
    p_read_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_valid && !in_wr) |=>
            (s2_valid && !s2_wr && s2_addr == $past(in_addr)));
endmodule

// File: rtl/nobl_mem_array.sv
// Word storage with per-lane write masking and a registered read port.
// A read looked up on the same edge as a write commit to the same address
// takes the incoming lanes, so back-to-back write/read needs no extra cycle.
// Assumes the commit and lookup addresses come from pipeline stages 2 and 1.
module nobl_mem_array
    import nobl_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  bws_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];
    logic [WORD_W-1:0] wmask;
    logic [WORD_W-1:0] fwd_mask;
    logic [WORD_W-1:0] rd_word;

    // Expand each lane select over its data bits and its parity bit.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign wmask[l*LANE_BITS +: LANE_BITS] = {LANE_BITS{~bws_n[l]}};
        assign wmask[DATA_W + l]               = ~bws_n[l];
    end

    // Merge the committing write into a same-address lookup.
    always_comb begin
        fwd_mask = (wr_commit && (wr_addr == rd_addr)) ? wmask : '0;
        rd_word  = (store[rd_addr] & ~fwd_mask) | (wdata & fwd_mask);
    end

    // Masked write of the stage-2 word on an enabled edge.
    always_ff @(posedge clk) begin
        if (en && wr_commit)
            store[wr_addr] <= (store[wr_addr] & ~wmask) | (wdata & wmask);
    end

    // Read register, loaded by a read in stage 1, frozen during stalls.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (en && rd_req)
            rdata <= rd_word;
    end

    // A stalled clock leaves the read register untouched.
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rdata));
endmodule

// File: rtl/nobl_sram.sv
// Top of the pipelined zero-turnaround SRAM model: burst front end, output
// stage and storage. The bus is split into input, output and drive enable.
// Assumes burst_mode is strapped and ADDR_W >= 2.
module nobl_sram
    import nobl_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [LANES-1:0]  bws_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              cen_n,
    input  logic              oe_n,
    input  logic              burst_mode,
    input  logic [WORD_W-1:0] dq_i,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_oe
);
    logic              en;
    logic              s1_valid;
    logic              s1_wr;
    logic [ADDR_W-1:0] s1_addr;
    logic              s2_valid;
    logic              s2_wr;
    logic [ADDR_W-1:0] s2_addr;
    logic [WORD_W-1:0] rdata;

    assign en = ~cen_n;

    nobl_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .addr       (addr),
        .adv_ld     (adv_ld),
        .we_n       (we_n),
        .ce1_n      (ce1_n),
        .ce2        (ce2),
        .ce3_n      (ce3_n),
        .burst_mode (burst_mode),
        .op_valid   (s1_valid),
        .op_wr      (s1_wr),
        .op_addr    (s1_addr)
    );

    nobl_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .in_valid (s1_valid),
        .in_wr    (s1_wr),
        .in_addr  (s1_addr),
        .oe_n     (oe_n),
        .s2_valid (s2_valid),
        .s2_wr    (s2_wr),
        .s2_addr  (s2_addr),
        .dq_oe    (dq_oe)
    );

    nobl_mem_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .wr_commit (s2_valid & s2_wr),
        .wr_addr   (s2_addr),
        .wdata     (dq_i),
        .bws_n     (bws_n),
        .rd_req    (s1_valid & ~s1_wr),
        .rd_addr   (s1_addr),
        .rdata     (rdata)
    );

    assign dq_o = rdata;

    // Two enabled edges after a selected write load, the bus is left free for write data.
    p_wdata_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && !ce1_n && ce2 && !ce3_n && !we_n) ##1 !cen_n
            |=> !dq_oe);

    // Two enabled edges after a deselecting load, the bus stays off.
    p_desel_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && !(!ce1_n && ce2 && !ce3_n)) ##1 !cen_n
            |=> !dq_oe);
endmodule

// File: tb/tb_nobl_sram.sv
// Bench: a behavioural reference (a two-entry queue of pending accesses and a
// reference array) is advanced on every enabled edge and compared at each falling edge.
module tb_nobl_sram;
    localparam int AW = 10;
    localparam logic [1:0] K_NOP = 2'd0, K_RD = 2'd1, K_WR = 2'd2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic adv_ld = 1'b0, we_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
    logic cen_n = 1'b0, oe_n = 1'b0, burst_mode = 1'b0;
    logic [1:0]  bws_n = 2'b11;
    logic [17:0] dq_i = '0;
    logic [17:0] dq_o;
    logic dq_oe;

    always #10 clk = ~clk;

    nobl_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adv_ld(adv_ld), .we_n(we_n),
        .bws_n(bws_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .cen_n(cen_n),
        .oe_n(oe_n), .burst_mode(burst_mode), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    typedef struct packed {
        logic [1:0]    kind;
        logic [AW-1:0] a;
        logic [17:0]   d;
        logic [1:0]    bw;
    } mop_t;

    mop_t q[$];
    logic [17:0] ref_mem [0:(1<<AW)-1];
    bit m_live = 0, m_wr = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_cnt = '0;
    logic [17:0] nxt_d = '0;
    logic [1:0]  nxt_bw = 2'b11;
    int n_chk = 0, n_fail = 0;
    string cur_req = "R12";

    function automatic logic [17:0] merge(logic [17:0] o, logic [17:0] n, logic [1:0] bw);
        logic [17:0] m = {~bw[1], ~bw[0], {8{~bw[1]}}, {8{~bw[0]}}};
        return (o & ~m) | (n & m);
    endfunction

    function automatic logic [17:0] pat(int a, int s);
        return 18'((a * 977 + s * 131 + 7) ^ 18'h2C3A1);
    endfunction

    // Reference: one access enters and the oldest retires per enabled edge.
    always @(posedge clk) begin
        mop_t f, n;
        logic [1:0] lo;
        if (!rst_n) begin
            q.delete(); q.push_back('0); q.push_back('0);
            m_live = 0; m_cnt = '0;
        end else if (!cen_n) begin
            f = q.pop_front();
            if (f.kind == K_WR) ref_mem[f.a] = merge(ref_mem[f.a], f.d, f.bw);
            n = '0;
            if (!adv_ld) begin
                if (!ce1_n && ce2 && !ce3_n) begin
                    m_live = 1; m_base = addr; m_cnt = '0; m_wr = !we_n;
                    n.kind = m_wr ? K_WR : K_RD; n.a = addr;
                end else m_live = 0;
            end else if (m_live) begin
                m_cnt = m_cnt + 2'd1;
                lo = burst_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
                n.kind = m_wr ? K_WR : K_RD; n.a = {m_base[AW-1:2], lo};
            end
            n.d = nxt_d; n.bw = nxt_bw;
            q.push_back(n);
        end
    end

    task automatic chk(bit ok, string what, logic [17:0] act, logic [17:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic observe();
        if (q.size() > 0 && q[0].kind == K_RD && !oe_n)
            chk(dq_oe === 1'b1 && dq_o === ref_mem[q[0].a], "read word",
                dq_oe ? dq_o : 18'h3FFFF, ref_mem[q[0].a]);
        else
            chk(dq_oe === 1'b0, "bus off", {17'b0, dq_oe}, 18'h0);
    endtask

    task automatic drive(bit ld, bit wr, int a, bit c1n, bit c2, bit c3n, bit cen,
                         logic [17:0] d, logic [1:0] bw);
        @(negedge clk);
        observe();
        adv_ld = ~ld; we_n = ~wr; addr = a[AW-1:0];
        ce1_n = c1n; ce2 = c2; ce3_n = c3n; cen_n = cen;
        nxt_d = d; nxt_bw = bw;
        if (q.size() > 0 && q[0].kind == K_WR) begin
            dq_i = q[0].d; bws_n = q[0].bw;
        end else begin
            dq_i = 18'h15A5A; bws_n = 2'b00;
        end
    endtask

    task automatic wr1(int a, logic [17:0] d, logic [1:0] bw); drive(1,1,a,0,1,0,0,d,bw); endtask
    task automatic rd1(int a); drive(1,0,a,0,1,0,0,'0,2'b11); endtask
    task automatic adv(logic [17:0] d); drive(0,0,0,1,0,1,0,d,2'b00); endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1,0,0,1,1,0,0,'0,2'b11);
    endtask

    initial begin
        #(20 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R12: reset empties the pipeline, bus off
        cur_req = "R12";
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R3: plain writes, then R2 reads back to back
        cur_req = "R3";
        for (int i = 0; i < 8; i++) wr1(i, pat(i, 0), 2'b00);
        for (int i = 0; i < 8; i++) wr1(32 + i, pat(32 + i, 0), 2'b00);
        cur_req = "R2";
        for (int i = 0; i < 8; i++) rd1(i);
        idle(2);

        // R11: asynchronous gating of the drive during a read data phase
        cur_req = "R11";
        rd1(3); idle(1);
        @(posedge clk); #5;
        oe_n = 1'b1; #1;
        chk(dq_oe === 1'b0, "oe_n high gates drive", {17'b0, dq_oe}, 18'h0);
        oe_n = 1'b0; #1;
        chk(dq_oe === 1'b1 && dq_o === pat(3, 0), "oe_n low restores drive", dq_o, pat(3, 0));
        idle(2);

        // R13: write/read alternation with no idle cycle
        cur_req = "R13";
        for (int i = 0; i < 6; i++) begin
            wr1(8 + i, pat(8 + i, 1), 2'b00);
            rd1(i);
        end
        idle(2);

        // R4: lane masks (lane 0 = bits 7:0 + bit 16, lane 1 = bits 15:8 + bit 17)
        cur_req = "R4";
        wr1(4, 18'h3FFFF, 2'b10);
        wr1(5, 18'h3FFFF, 2'b01);
        wr1(6, 18'h3FFFF, 2'b11);
        idle(1);
        rd1(4); rd1(5); rd1(6);
        idle(2);

        // R5: same-address read right after a write (full and masked)
        cur_req = "R5";
        wr1(20, pat(20, 3), 2'b00); rd1(20);
        wr1(20, 18'h00000, 2'b01); rd1(20);
        wr1(7, 18'h3F00F, 2'b10); rd1(7); rd1(7);
        idle(2);

        // R6: stall with junk (a write load) on the inputs, then resume
        cur_req = "R6";
        rd1(1); rd1(2);
        drive(1,1,33,0,1,0,1,18'h3FFFF,2'b00);
        drive(1,1,33,0,1,0,1,18'h3FFFF,2'b00);
        drive(1,1,33,0,1,0,1,18'h3FFFF,2'b00);
        rd1(33); idle(1);
        wr1(34, pat(34, 5), 2'b00);
        drive(0,0,0,0,1,0,1,'0,2'b11);
        drive(0,0,0,0,1,0,1,'0,2'b11);
        rd1(34);
        idle(2);

        // R1: each failing select combination suppresses the write
        cur_req = "R1";
        drive(1,1,32,1,1,0,0,18'h11111,2'b00);
        drive(1,1,32,0,0,0,0,18'h22222,2'b00);
        drive(1,1,32,0,1,1,0,18'h33333,2'b00);
        drive(1,0,32,0,0,0,0,'0,2'b11);
        idle(1);
        rd1(32);
        idle(2);

        // R10: read directly after a deselect, write data phases, oe_n ignored when off
        cur_req = "R10";
        idle(1); rd1(33); rd1(34); idle(1); rd1(35);
        wr1(36, pat(36, 6), 2'b00); rd1(35); wr1(37, pat(37, 6), 2'b00);
        idle(2);

        // R8: linear bursts, write from base 0x42 and read from base 0x40 with wrap
        cur_req = "R8";
        burst_mode = 1'b0;
        wr1(66, pat(66, 8), 2'b00);
        for (int i = 0; i < 3; i++) adv(pat(i, 9));
        rd1(64);
        for (int i = 0; i < 4; i++) adv('0);
        idle(2);
        for (int i = 64; i < 68; i++) rd1(i);
        idle(2);

        // R9: interleaved burst from base 0x51 (order 1,0,3,2)
        cur_req = "R9";
        burst_mode = 1'b1;
        wr1(81, pat(81, 10), 2'b00);
        for (int i = 0; i < 3; i++) adv(pat(i, 11));
        idle(1);
        for (int i = 80; i < 84; i++) rd1(i);
        rd1(82);
        for (int i = 0; i < 3; i++) adv('0);
        idle(2);
        burst_mode = 1'b0;

        // R7: advance ignores we_n; advance after a deselect does nothing
        cur_req = "R7";
        wr1(97, pat(97, 12), 2'b00);
        wr1(96, pat(96, 12), 2'b00);
        idle(1);
        adv(18'h3FFFF);
        drive(0,1,0,0,1,0,0,18'h3FFFF,2'b00);
        idle(1);
        rd1(96); adv('0);
        idle(2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule